// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch Map

This block is the control sequencer of a multicycle 32-bit load/store processor. It keeps a microprogram counter and a writable store of 32-bit microwords. Every clock it decides which microword comes next and presents that microword to the datapath. The decision comes from a two-bit select field in the current microword. The counter can step forward by one, return to the fetch routine at microaddress 0, jump to an 8-bit target held in the microword, or dispatch through a 128-entry map that is indexed from the fetched instruction.

The dispatch index depends on the instruction format. An instruction whose 6-bit opcode is zero is register-format, and its index is its 6-bit function code with bit 6 set. For any other instruction the index is the opcode with bit 6 clear. A microword can also arm an overflow trap. When it is armed and the ALU flags signed overflow, control goes to a trap routine, whatever the select field says.

The microword store and the map are loaded through dedicated write ports. After reset, every map entry points to the undefined-instruction routine.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is asserted, `upc` is 0 and `uword` is 0. On the first clock after reset is released, `upc` stays 0 and `uword` becomes the stored word at address 0. From then on the sequencer advances from that word.
- R2: Select code 0 (microword bits 31:30 = 2'b00) loads `upc` with the current address plus one, wrapping from 0xFF to 0x00.
- R3: Select code 1 loads `upc` with 0, the fetch routine.
- R4: Select code 2 loads `upc` with the map entry at the dispatch index.
- R5: The dispatch index is {1, ir[5:0]} when ir[31:26] is 0, and {0, ir[31:26]} otherwise. Index 0x7F is therefore reached only by a register-format instruction with function code 0x3F.
- R6: Select code 3 loads `upc` with microword bits 8:1.
- R7: When microword bit 29 is 1 and `alu_ovf` is 1 in the same cycle, `upc` is next loaded with TRAP_UADDR (default 0xF8) and the select field is ignored. Setting only one of the two has no effect on sequencing.
- R8: `uword` always equals the stored microword at address `upc`, because the store is read synchronously with the counter update.
- R9: After reset, every map entry holds UNDEF_UADDR (default 0xF0).
- R10: A map write (`map_we`) replaces the entry at `map_waddr` with effect from the next cycle. Map writes are ignored while reset is asserted.
- R11: A microword write (`uc_we`) stores `uc_wdata` at `uc_waddr`. Any later fetch of that address returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 32 | Current instruction register |
| alu_ovf | input | 1 | ALU signed overflow flag |
| uc_we | input | 1 | Microword store write enable |
| uc_waddr | input | 8 | Microword store write address |
| uc_wdata | input | 32 | Microword store write data |
| map_we | input | 1 | Dispatch map write enable |
| map_waddr | input | 7 | Dispatch map write index |
| map_wdata | input | 8 | Dispatch map entry data (microaddress) |
| uword | output | 32 | Current microword to the datapath |
| upc | output | 8 | Current microprogram counter |

## Verification
A wrong counter value is visible on `upc` one cycle after the edge that loaded it. On the same cycle `uword` shows the word from the wrong address, so a single bad step shows up at once and the rest of the trajectory differs from the expected routine. A bad map entry or a mis-formed dispatch index shows up one cycle after decode as the wrong routine entry, for example the undefined routine instead of the load routine. A missed or spurious overflow diversion shows up as `upc` reaching, or failing to reach, the trap address on the next cycle. The bench follows each instruction class through its routine step by step and compares `upc` and `uword` against an image of the microcode it keeps itself.

// File: rtl/useq_pkg.sv
package useq_pkg;
   typedef enum logic [1:0] {
      NA_INC   = 2'd0,
      NA_FETCH = 2'd1,
      NA_MAP   = 2'd2,
      NA_JUMP  = 2'd3
   } na_sel_e;

   localparam int SEL_LSB  = 30;
   localparam int TRAP_BIT = 29;
   localparam int TGT_LSB  = 1;
   localparam int OPC_LSB  = 26;
   localparam int OPC_W    = 6;
   localparam int FN_W     = 6;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
   parameter int WORD_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= mem[raddr];
   end
endmodule

// File: rtl/useq_map.sv
module useq_map
   import useq_pkg::*;
#(
   parameter int IDX_W       = 7,
   parameter int ADDR_W      = 8,
   parameter int UNDEF_UADDR = 'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  opc,
   input  logic [FN_W-1:0]   fn,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] target
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W != OPC_W + 1) begin : g_bad_idx
      $error("map index must be one bit wider than the opcode");
   end
   if (FN_W != OPC_W) begin : g_bad_fn
      $error("function and opcode fields must have equal width");
   end

   logic [ADDR_W-1:0] ent [DEPTH];
   logic [IDX_W-1:0]  idx;

   always_comb begin
      if (opc == '0) idx = {1'b1, fn};
      else           idx = {1'b0, opc};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent[i] <= ADDR_W'(UNDEF_UADDR);
      end else if (we) begin
         ent[waddr] <= wdata;
      end
   end

   assign target = ent[idx];
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter bit OVF_TRAP_EN = 1'b1,
   parameter int TRAP_UADDR  = 'hF8,
   parameter int FETCH_UADDR = 0
) (
   input  logic [1:0]        sel,
   input  logic              trap_arm,
   input  logic [ADDR_W-1:0] jump_tgt,
   input  logic [ADDR_W-1:0] map_tgt,
   input  logic [ADDR_W-1:0] upc,
   input  logic              alu_ovf,
   output logic [ADDR_W-1:0] nxt
);
   logic          trap_take;
   logic [ADDR_W-1:0] norm;

   if (OVF_TRAP_EN) begin : g_trap
      assign trap_take = trap_arm & alu_ovf;
   end else begin : g_notrap
      logic unused_trap_in;
      assign unused_trap_in = trap_arm ^ alu_ovf;
      assign trap_take      = 1'b0;
   end

   always_comb begin
      case (na_sel_e'(sel))
         NA_INC:   norm = upc + 1'b1;
         NA_FETCH: norm = ADDR_W'(FETCH_UADDR);
         NA_MAP:   norm = map_tgt;
         default:  norm = jump_tgt;
      endcase
   end

   assign nxt = trap_take ? ADDR_W'(TRAP_UADDR) : norm;
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
   import useq_pkg::*;
#(
   parameter int UWORD_W     = 32,
   parameter int UADDR_W     = 8,
   parameter int MAP_IDX_W   = 7,
   parameter bit OVF_TRAP_EN = 1'b1,
   parameter int UNDEF_UADDR = 'hF0,
   parameter int TRAP_UADDR  = 'hF8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [31:0]        ir,
   input  logic               alu_ovf,
   input  logic               uc_we,
   input  logic [UADDR_W-1:0] uc_waddr,
   input  logic [UWORD_W-1:0] uc_wdata,
   input  logic               map_we,
   input  logic [MAP_IDX_W-1:0] map_waddr,
   input  logic [UADDR_W-1:0] map_wdata,
   output logic [UWORD_W-1:0] uword,
   output logic [UADDR_W-1:0] upc
);
   localparam int FETCH_UADDR = 0;
   localparam int TGT_MSB     = TGT_LSB + UADDR_W - 1;

   if (UWORD_W != 32) begin : g_bad_w
      $error("microword layout assumes 32 bits");
   end
   if (TGT_MSB >= TRAP_BIT) begin : g_bad_aw
      $error("jump target overlaps the trap enable bit");
   end
   if (UNDEF_UADDR >= (1 << UADDR_W) || TRAP_UADDR >= (1 << UADDR_W)) begin : g_bad_vec
      $error("routine addresses exceed the microaddress space");
   end

   logic               booted;
   logic [UADDR_W-1:0] nxt;
   logic [UADDR_W-1:0] seq_nxt;
   logic [UADDR_W-1:0] map_tgt;
   logic               unused_ir_bits;

   assign unused_ir_bits = ^ir[OPC_LSB-1:FN_W];

   useq_store #(.WORD_W(UWORD_W), .ADDR_W(UADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(uc_we), .waddr(uc_waddr), .wdata(uc_wdata),
      .raddr(seq_nxt), .rdata(uword)
   );

   useq_map #(.IDX_W(MAP_IDX_W), .ADDR_W(UADDR_W), .UNDEF_UADDR(UNDEF_UADDR)) u_map (
      .clk(clk), .rst_n(rst_n), .opc(ir[OPC_LSB +: OPC_W]), .fn(ir[FN_W-1:0]),
      .we(map_we), .waddr(map_waddr), .wdata(map_wdata), .target(map_tgt)
   );

   useq_next #(.ADDR_W(UADDR_W), .OVF_TRAP_EN(OVF_TRAP_EN),
               .TRAP_UADDR(TRAP_UADDR), .FETCH_UADDR(FETCH_UADDR)) u_next (
      .sel(uword[SEL_LSB +: 2]), .trap_arm(uword[TRAP_BIT]),
      .jump_tgt(uword[TGT_MSB:TGT_LSB]), .map_tgt(map_tgt), .upc(upc),
      .alu_ovf(alu_ovf), .nxt(nxt)
   );

   assign seq_nxt = booted ? nxt : UADDR_W'(FETCH_UADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         booted <= 1'b0;
         upc    <= '0;
      end else begin
         booted <= 1'b1;
         upc    <= seq_nxt;
      end
   end

   logic trap_now;
   assign trap_now = OVF_TRAP_EN && uword[TRAP_BIT] && alu_ovf;

   // R1
   boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !booted |=> (upc == '0));

   // R2
   upc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      booted && uword[SEL_LSB +: 2] == 2'd0 && !trap_now
      |=> upc == UADDR_W'($past(upc) + 1'b1));

   // R3
   fetch_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      booted && uword[SEL_LSB +: 2] == 2'd1 && !trap_now |=> upc == '0);

   // R6
   jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      booted && uword[SEL_LSB +: 2] == 2'd3 && !trap_now
      |=> upc == $past(uword[TGT_MSB:TGT_LSB]));

   // R7
   ovf_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      booted && trap_now |=> upc == UADDR_W'(TRAP_UADDR));
endmodule

// File: tb/tb_useq_sequencer.sv
module tb_useq_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ir = '0;
   logic        alu_ovf = 1'b0;
   logic        uc_we = 1'b0;
   logic [7:0]  uc_waddr = '0;
   logic [31:0] uc_wdata = '0;
   logic        map_we = 1'b0;
   logic [6:0]  map_waddr = '0;
   logic [7:0]  map_wdata = '0;
   logic [31:0] uword;
   logic [7:0]  upc;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   logic [31:0] img [256];

   useq_sequencer dut (
      .clk(clk), .rst_n(rst_n), .ir(ir), .alu_ovf(alu_ovf),
      .uc_we(uc_we), .uc_waddr(uc_waddr), .uc_wdata(uc_wdata),
      .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata),
      .uword(uword), .upc(upc)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == 60000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog act=%0d exp=finished", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic [31:0] mw(input logic [1:0] sel, input logic trap,
                                      input logic [7:0] tgt, input logic [19:0] tag);
      return {sel, trap, tag, tgt, 1'b0};
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wait_upc(input logic [7:0] a);
      step();
      while (upc !== a) step();
   endtask

   function automatic logic [31:0] rform(input logic [5:0] fn);
      return {6'h00, 20'hABCDE, fn};
   endfunction

   function automatic logic [31:0] iform(input logic [5:0] op);
      return {op, 26'h155_5555};
   endfunction

   task automatic map_wr(input logic [6:0] i, input logic [7:0] d);
      map_we = 1'b1; map_waddr = i; map_wdata = d;
      step();
      map_we = 1'b0;
   endtask

   // start a routine: instruction set before fetch, stop at decode
   task automatic start(input logic [31:0] instr);
      ir = instr;
      wait_upc(8'h00);
      step();
      chk("R2 decode follows fetch", 32'(upc), 32'h01);
   endtask

   task automatic t_reset();
      for (int a = 0; a < 256; a++) img[a] = mw(2'd1, 1'b0, 8'h00, 20'(a));
      img[8'h00] = mw(2'd0, 1'b0, 8'h00, 20'h0F00D);
      img[8'h01] = mw(2'd2, 1'b0, 8'h00, 20'h0DEC0);
      img[8'h10] = mw(2'd3, 1'b1, 8'h12, 20'h0A100);
      img[8'h11] = mw(2'd3, 1'b0, 8'h12, 20'h0A110);
      img[8'h20] = mw(2'd0, 1'b0, 8'h00, 20'h01D20);
      img[8'h21] = mw(2'd0, 1'b0, 8'h00, 20'h01D21);
      img[8'hFF] = mw(2'd0, 1'b0, 8'h00, 20'h0FFFF);
      rst_n = 1'b0;
      ir = iform(6'h23);
      step();
      chk("R1 upc in reset", 32'(upc), 32'h0);
      chk("R1 uword in reset", uword, 32'h0);
      for (int a = 0; a < 256; a++) begin
         uc_we = 1'b1; uc_waddr = 8'(a); uc_wdata = img[a];
         step();
      end
      uc_we = 1'b0;
      map_wr(7'h23, 8'h20);
      chk("R1 upc still zero", 32'(upc), 32'h0);
      rst_n = 1'b1;
      step();
      chk("R1 first cycle upc", 32'(upc), 32'h0);
      chk("R1 first cycle uword", uword, img[0]);
      step();
      chk("R2 upc after fetch", 32'(upc), 32'h01);
      chk("R8 uword at decode", uword, img[1]);
      step();
      chk("R9 default entry undefined, R10 reset write ignored", 32'(upc), 32'hF0);
      step();
      chk("R3 undefined returns to fetch", 32'(upc), 32'h00);
   endtask

   task automatic t_load_map();
      map_wr(7'h40, 8'h10);
      map_wr(7'h60, 8'h10);
      map_wr(7'h61, 8'h11);
      map_wr(7'h23, 8'h20);
      map_wr(7'h63, 8'h30);
      map_wr(7'h7F, 8'hF8);
      map_wr(7'h3E, 8'hFF);
   endtask

   task automatic t_load_word();
      start(iform(6'h23));
      step();
      chk("R4 R10 lw dispatch", 32'(upc), 32'h20);
      step();
      chk("R2 lw step", 32'(upc), 32'h21);
      chk("R8 lw word", uword, img[8'h21]);
      step();
      chk("R2 lw last", 32'(upc), 32'h22);
      step();
      chk("R3 lw return", 32'(upc), 32'h00);
   endtask

   task automatic t_rfmt_index();
      start(rform(6'h23));
      step();
      chk("R5 function 0x23 indexes 0x63", 32'(upc), 32'h30);
      step();
      chk("R3 return from 0x30", 32'(upc), 32'h00);
      start(iform(6'h3F));
      step();
      chk("R5 opcode 0x3F keeps bit6 clear", 32'(upc), 32'hF0);
      start(rform(6'h3F));
      step();
      chk("R5 reserved index 0x7F", 32'(upc), 32'hF8);
   endtask

   task automatic t_nop_jump();
      start(rform(6'h00));
      step();
      chk("R4 nop to alu routine", 32'(upc), 32'h10);
      step();
      chk("R6 explicit jump", 32'(upc), 32'h12);
      step();
      chk("R3 alu return", 32'(upc), 32'h00);
   endtask

   task automatic t_overflow();
      start(rform(6'h20));
      step();
      chk("R4 add dispatch", 32'(upc), 32'h10);
      alu_ovf = 1'b1;
      step();
      chk("R7 overflow trap taken", 32'(upc), 32'hF8);
      alu_ovf = 1'b0;
      step();
      chk("R3 trap returns", 32'(upc), 32'h00);
      ir = rform(6'h21);
      wait_upc(8'h00);
      step();
      alu_ovf = 1'b1;
      step();
      chk("R7 overflow ignored at decode", 32'(upc), 32'h11);
      step();
      chk("R7 overflow ignored when unarmed", 32'(upc), 32'h12);
      alu_ovf = 1'b0;
      step();
      chk("R3 addu return", 32'(upc), 32'h00);
   endtask

   task automatic t_wrap();
      start(iform(6'h3E));
      step();
      chk("R4 dispatch to top", 32'(upc), 32'hFF);
      step();
      chk("R2 increment wraps", 32'(upc), 32'h00);
      chk("R8 word after wrap", uword, img[0]);
   endtask

   task automatic t_ucode_write();
      ir = rform(6'h23);
      wait_upc(8'h00);
      img[8'h30] = mw(2'd3, 1'b0, 8'h12, 20'h0BEEF);
      uc_we = 1'b1; uc_waddr = 8'h30; uc_wdata = img[8'h30];
      step();
      uc_we = 1'b0;
      wait_upc(8'h00);
      step();
      step();
      chk("R11 rewritten routine entered", 32'(upc), 32'h30);
      chk("R11 new word visible", uword, img[8'h30]);
      step();
      chk("R11 R6 new word jumps", 32'(upc), 32'h12);
   endtask

   initial begin
      t_reset();
      t_load_map();
      t_load_word();
      t_rfmt_index();
      t_nop_jump();
      t_overflow();
      t_wrap();
      t_ucode_write();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule